// File: doc/BRIEF.md
# Partitioned pixel pack and merge unit

This block is a SIMD datapath that moves pixel data between fixed-point and byte formats. One operation select picks among five conversions. Three of them narrow wide signed lanes to bytes or halfwords with saturation. The other two widen bytes to 16-bit fixed point or interleave the bytes of two words. The three narrowing conversions first shift each lane left by a scale factor read from a 64-bit graphics status input. They then apply an arithmetic right shift that depends on the operation. Last, they clamp the lane into its output range.

The conversion logic is purely combinational. A parameter selects either an output register, so a valid input gives a valid result one clock later, or a direct path. Results that are 32 bits wide are returned in the low half of the 64-bit output, with the high half zero. Operand fetch and instruction decode are left to the surrounding pipeline.

Top module: `pix_pack_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears out_valid and result to zero.
- R2: With the output register enabled, out_valid equals in_valid from the previous clock. result loads only on cycles with in_valid high and holds otherwise.
- R3: For op code 0 (pack16), the scale is gsr[6:3]. gsr bit 7 has no effect on the result.
- R4: Pack16 applies the same steps to each signed 16-bit lane i of src_b (bits 16i+15:16i). It shifts the lane left by the scale, shifts it arithmetically right by 7, clamps it to 0..255, and writes the byte to result bits 8i+7:8i. result[63:32] is zero.
- R5: For op code 1 (pack32), each 32-bit half of the result starts from src_a shifted left by 8 bits, with bytes 0 and 4 cleared. Half j bits 31:8 are therefore src_a[32j+23:32j].
- R6: Pack32 applies the same steps to each signed 32-bit word j of src_b. It shifts the word left by the scale gsr[7:3], shifts it arithmetically right by 23, clamps it to 0..255, and places the byte in result byte 4j.
- R7: For op code 2 (packfix), each signed 32-bit word j of src_b is shifted left by gsr[7:3], shifted arithmetically right by 16, and clamped to -32768..32767. The 16-bit two's-complement value goes to result bits 16j+15:16j, and result[63:32] is zero.
- R8: For op code 3 (expand), each byte k of src_b[31:0] becomes the 16-bit lane k of the result, equal to the byte times 16 with the top 4 bits zero.
- R9: For op code 4 (merge), result byte 2k is byte k of src_b and result byte 2k+1 is byte k of src_a, for k = 0..3.
- R10: Op codes 5, 6 and 7 produce an all-zero result.
- R11: gsr bits 2:0 and 63:8 have no effect on any operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Inputs carry an operation this cycle |
| op_sel | input | 3 | Operation code: 0 pack16, 1 pack32, 2 packfix, 3 expand, 4 merge |
| src_a | input | 64 | First operand (pack32 accumulator, merge odd bytes) |
| src_b | input | 64 | Second operand (lanes to convert) |
| gsr | input | 64 | Graphics status word holding the scale in bits 7:3 |
| out_valid | output | 1 | result holds a new value |
| result | output | 64 | Converted data; 32-bit results in the low half |

## Verification
The datapath holds no state apart from the output register. A wrong shift width or a wrong clamp bound therefore shows up in the result of the very vector that exercises it, one clock after it is presented. Errors in the scale field's bit positions only appear at particular scale values. For this reason the bench sweeps every scale for each narrowing operation and places lanes near the clamp limits and at the sign extremes. A fault in the valid register or in the hold behaviour shows up on the cycle after in_valid drops.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;
  localparam int WORD_W   = 64;
  localparam int HALF_W   = WORD_W / 2;
  localparam int N16      = WORD_W / 16;
  localparam int N32      = WORD_W / 32;
  localparam int NB_HALF  = HALF_W / 8;
  localparam int SC_LSB   = 3;
  localparam int SC16_W   = 4;
  localparam int SC32_W   = 5;
  localparam int SH16     = 7;
  localparam int SH32B    = 23;
  localparam int SH32H    = 16;

  typedef enum logic [2:0] {
    OP_PACK16  = 3'd0,
    OP_PACK32  = 3'd1,
    OP_PACKFIX = 3'd2,
    OP_EXPAND  = 3'd3,
    OP_MERGE   = 3'd4
  } pix_op_e;

  // scale a 16-bit lane in 32 bits, then drop the 7 fraction bits
  function automatic logic signed [31:0] fx16_align(input logic [15:0] x,
                                                    input logic [SC16_W-1:0] s);
    logic signed [31:0] w;
    w = $signed({{16{x[15]}}, x});
    w = w <<< s;
    return w >>> SH16;
  endfunction

  // scale a 32-bit word in 64 bits (no overflow for s <= 31)
  function automatic logic signed [63:0] fx32_scale(input logic [31:0] x,
                                                    input logic [SC32_W-1:0] s);
    logic signed [63:0] w;
    w = $signed({{32{x[31]}}, x});
    return w <<< s;
  endfunction

  function automatic logic [7:0] sat_u8(input logic signed [63:0] v);
    if (v < 64'sd0)        return 8'h00;
    else if (v > 64'sd255) return 8'hff;
    else                   return v[7:0];
  endfunction

  function automatic logic [15:0] sat_s16(input logic signed [63:0] v);
    if (v < -64'sd32768)     return 16'h8000;
    else if (v > 64'sd32767) return 16'h7fff;
    else                     return v[15:0];
  endfunction
endpackage

// File: rtl/pix_pack_lanes.sv
module pix_pack_lanes
  import pix_pack_pkg::*;
(
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  input  logic [WORD_W-1:0] gsr,
  output logic [WORD_W-1:0] pk16_res,
  output logic [WORD_W-1:0] pk32_res,
  output logic [WORD_W-1:0] pkfix_res
);
  logic [SC16_W-1:0] scale16;
  logic [SC32_W-1:0] scale32;
  assign scale16 = gsr[SC_LSB +: SC16_W];
  assign scale32 = gsr[SC_LSB +: SC32_W];

  // observable saturation events
  logic [N16-1:0] sat16_hi, sat16_lo;
  logic [N32-1:0] sat32_hi, sat32_lo, satfx_hi, satfx_lo;

  assign pk16_res[WORD_W-1:HALF_W]  = '0;
  assign pkfix_res[WORD_W-1:HALF_W] = '0;

  for (genvar i = 0; i < N16; i++) begin : g_l16
    logic signed [31:0] al16;
    logic [7:0]         byte16;
    assign al16        = fx16_align(src_b[16*i +: 16], scale16);
    assign sat16_hi[i] = al16 > 32'sd255;
    assign sat16_lo[i] = al16 < 32'sd0;
    assign byte16      = sat_u8(64'(al16));
    assign pk16_res[8*i +: 8] = byte16;
    always_comb begin
      // R4
      pk16_hi_chk: assert (!sat16_hi[i] || byte16 == 8'hff);
      // R4
      pk16_lo_chk: assert (!sat16_lo[i] || byte16 == 8'h00);
    end
  end

  for (genvar j = 0; j < N32; j++) begin : g_l32
    logic signed [63:0] sc32, al23, al16w;
    logic [7:0]         byte32;
    logic [15:0]        half16;
    assign sc32  = fx32_scale(src_b[32*j +: 32], scale32);
    assign al23  = sc32 >>> SH32B;
    assign al16w = sc32 >>> SH32H;
    assign sat32_hi[j] = al23 > 64'sd255;
    assign sat32_lo[j] = al23 < 64'sd0;
    assign satfx_hi[j] = al16w > 64'sd32767;
    assign satfx_lo[j] = al16w < -64'sd32768;
    assign byte32 = sat_u8(al23);
    assign half16 = sat_s16(al16w);
    // accumulator: src_a moved up one byte, byte 0 of each half replaced
    assign pk32_res[32*j +: 32] = {src_a[32*j +: 24], byte32};
    assign pkfix_res[16*j +: 16] = half16;
    always_comb begin
      // R6
      pk32_hi_chk: assert (!sat32_hi[j] || byte32 == 8'hff);
      // R7
      pkfix_hi_chk: assert (!satfx_hi[j] || half16 == 16'h7fff);
      // R7
      pkfix_lo_chk: assert (!satfx_lo[j] || half16 == 16'h8000);
    end
  end
endmodule

// File: rtl/pix_widen_merge.sv
module pix_widen_merge
  import pix_pack_pkg::*;
(
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  output logic [WORD_W-1:0] exp_res,
  output logic [WORD_W-1:0] mrg_res
);
  for (genvar k = 0; k < NB_HALF; k++) begin : g_byte
    assign exp_res[16*k +: 16] = {4'b0000, src_b[8*k +: 8], 4'b0000};
    assign mrg_res[16*k +: 16] = {src_a[8*k +: 8], src_b[8*k +: 8]};
  end
endmodule

// File: rtl/pix_out_stage.sv
module pix_out_stage
  import pix_pack_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_valid,
  input  logic [WORD_W-1:0] d,
  output logic              q_valid,
  output logic [WORD_W-1:0] q
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q_valid <= 1'b0;
        q       <= '0;
      end else begin
        q_valid <= d_valid;
        if (d_valid) q <= d;
      end
    end
  end else begin : g_pass
    assign q_valid = d_valid;
    assign q       = d;
  end
endmodule

// File: rtl/pix_pack_unit.sv
module pix_pack_unit
  import pix_pack_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  input  logic [WORD_W-1:0] gsr,
  output logic              out_valid,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] pk16_res, pk32_res, pkfix_res, exp_res, mrg_res;
  logic [WORD_W-1:0] sel_res;

  pix_pack_lanes u_lanes (
    .src_a     (src_a),
    .src_b     (src_b),
    .gsr       (gsr),
    .pk16_res  (pk16_res),
    .pk32_res  (pk32_res),
    .pkfix_res (pkfix_res)
  );

  pix_widen_merge u_wm (
    .src_a   (src_a),
    .src_b   (src_b),
    .exp_res (exp_res),
    .mrg_res (mrg_res)
  );

  always_comb begin
    case (op_sel)
      OP_PACK16:  sel_res = pk16_res;
      OP_PACK32:  sel_res = pk32_res;
      OP_PACKFIX: sel_res = pkfix_res;
      OP_EXPAND:  sel_res = exp_res;
      OP_MERGE:   sel_res = mrg_res;
      default:    sel_res = '0;
    endcase
  end

  pix_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d       (sel_res),
    .q_valid (out_valid),
    .q       (result)
  );

  if (REG_OUT) begin : g_chk
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(result)));
    // R4
    pk16_upper_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == OP_PACK16) |=> result[WORD_W-1:HALF_W] == '0);
    // R7
    pkfix_upper_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == OP_PACKFIX) |=> result[WORD_W-1:HALF_W] == '0);
    // R10
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel > 3'd4) |=> result == '0);
  end
endmodule

// File: tb/sim_pix_pack_unit.sv
`timescale 1ns/1ps
module sim_pix_pack_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [63:0] src_a = '0, src_b = '0, gsr = '0;
  logic        out_valid;
  logic [63:0] result;
  int n_cmp = 0, n_bad = 0;
  logic [63:0] seed = 64'h1234_5678_9abc_def0;

  always #2 clk = ~clk;

  pix_pack_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .gsr(gsr),
    .out_valid(out_valid), .result(result)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nxt(output logic [63:0] v);
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    v = seed ^ (seed >> 29);
  endtask

  function automatic longint fdiv(input longint v, input longint d);
    longint q;
    q = v / d;
    if ((v % d) != 0 && v < 0) q = q - 1;
    return q;
  endfunction

  function automatic longint lim(input longint v, input longint lo, input longint hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic logic [63:0] e_pack16(input logic [63:0] b, input logic [63:0] g);
    logic [63:0] r = '0;
    int s = int'(g[6:3]);
    for (int i = 0; i < 4; i++) begin
      longint v = longint'($signed(b[16*i +: 16]));
      v = lim(fdiv(v * (longint'(1) << s), 128), 0, 255);
      r[8*i +: 8] = v[7:0];
    end
    return r;
  endfunction

  function automatic logic [63:0] e_pack32(input logic [63:0] a, input logic [63:0] b,
                                           input logic [63:0] g);
    logic [63:0] r;
    int s = int'(g[7:3]);
    r = (a << 8) & ~64'h0000_00ff_0000_00ff;
    for (int j = 0; j < 2; j++) begin
      longint v = longint'($signed(b[32*j +: 32]));
      v = lim(fdiv(v * (longint'(1) << s), 64'sd8388608), 0, 255);
      r[32*j +: 8] = v[7:0];
    end
    return r;
  endfunction

  function automatic logic [63:0] e_packfix(input logic [63:0] b, input logic [63:0] g);
    logic [63:0] r = '0;
    int s = int'(g[7:3]);
    for (int j = 0; j < 2; j++) begin
      longint v = longint'($signed(b[32*j +: 32]));
      v = lim(fdiv(v * (longint'(1) << s), 65536), -32768, 32767);
      r[16*j +: 16] = v[15:0];
    end
    return r;
  endfunction

  function automatic logic [63:0] e_expand(input logic [63:0] b);
    logic [63:0] r = '0;
    for (int k = 0; k < 4; k++) r[16*k +: 16] = 16'(b[8*k +: 8]) * 16'd16;
    return r;
  endfunction

  function automatic logic [63:0] e_merge(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++)
      r[8*k +: 8] = (k % 2 == 0) ? b[8*(k/2) +: 8] : a[8*(k/2) +: 8];
    return r;
  endfunction

  task automatic run_vec(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] g, input logic [63:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; src_a = a; src_b = b; gsr = g;
    @(negedge clk);
    chk(req, result, exp);
    chk("R2 valid", {63'b0, out_valid}, 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] a, b, g, held;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid", {63'b0, out_valid}, 64'd0);
    chk("R1 result", result, 64'd0);
    rst = 1'b0;

    // R3 R4 R11: every pack16 scale, junk in the other gsr bits
    for (int s = 0; s < 16; s++)
      for (int t = 0; t < 64; t++) begin
        nxt(a); nxt(b); nxt(g);
        if (t == 0) b = 64'h8000_7fff_0000_ffff;
        if (t == 1) b = 64'h0001_00ff_0100_ff80;
        g[6:3] = 4'(s);
        if (t % 2 == 1) run_vec(3'd0, a, b, g, e_pack16(b, g), "R3/R11 pack16 scale field");
        else            run_vec(3'd0, a, b, g, e_pack16(b, g), "R4 pack16");
      end

    // R5 R6: pack32 over all 5-bit scales
    for (int s = 0; s < 32; s++)
      for (int t = 0; t < 32; t++) begin
        nxt(a); nxt(b); nxt(g);
        if (t == 0) b = 64'h8000_0000_7fff_ffff;
        if (t == 1) b = 64'h0000_0080_ffff_ff00;
        g[7:3] = 5'(s);
        if (t % 2 == 0) run_vec(3'd1, a, b, g, e_pack32(a, b, g), "R5 pack32 accumulator");
        else            run_vec(3'd1, a, b, g, e_pack32(a, b, g), "R6 pack32 lanes");
      end

    // R7: packfix over all scales
    for (int s = 0; s < 32; s++)
      for (int t = 0; t < 32; t++) begin
        nxt(a); nxt(b); nxt(g);
        if (t == 0) b = 64'h8000_0000_7fff_ffff;
        if (t == 1) b = 64'hffff_8000_0000_7fff;
        g[7:3] = 5'(s);
        run_vec(3'd2, a, b, g, e_packfix(b, g), "R7 packfix");
      end

    // R8 expand, R9 merge
    for (int t = 0; t < 128; t++) begin
      nxt(a); nxt(b); nxt(g);
      if (t == 0) b = 64'hffff_ffff_ffff_ffff;
      run_vec(3'd3, a, b, g, e_expand(b), "R8 expand");
    end
    for (int t = 0; t < 128; t++) begin
      nxt(a); nxt(b); nxt(g);
      run_vec(3'd4, a, b, g, e_merge(a, b), "R9 merge");
    end

    // R10 unused codes
    for (int t = 0; t < 48; t++) begin
      nxt(a); nxt(b); nxt(g);
      run_vec(3'(5 + t % 3), a, b, g, 64'd0, "R10 unused op");
    end

    // R2: valid drop holds result
    nxt(a); nxt(b);
    run_vec(3'd4, a, b, 64'd0, e_merge(a, b), "R9 merge before hold");
    held = e_merge(a, b);
    @(negedge clk);
    in_valid = 1'b0; op_sel = 3'd3; src_b = ~b;
    @(negedge clk);
    chk("R2 valid low", {63'b0, out_valid}, 64'd0);
    chk("R2 hold", result, held);
    @(negedge clk);
    chk("R2 hold again", result, held);

    // R1: mid-run reset
    run_vec(3'd3, a, 64'h0102_0304_0506_0708, 64'd0, e_expand(64'h0102_0304_0506_0708), "R8 expand");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset valid", {63'b0, out_valid}, 64'd0);
    chk("R1 reset result", result, 64'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule